// File: doc/BRIEF.md
# Optimal-Filter Energy and Timing Processor

This block turns a window of five digitized calorimeter samples into an energy estimate, and for pulses large enough to matter, into a timing product and a pulse-quality figure. Each window arrives tagged with a channel number. The block subtracts that channel's pedestal from every sample. It then weights the five differences with the channel's own energy coefficients, and the sum scaled by a fixed number of fraction bits gives the energy. When the energy is strictly above a programmable threshold, the block also forms the weighted timing sum and the sum of squared residuals between the samples and the scaled pulse shape.

A single 18x18 signed multiplier and one accumulator serve every channel and every term. A small controller steps them through the energy, timing and quality passes in turn. Pedestals and the three coefficient sets (energy, timing, shape) are stored per channel. They are written through a configuration port that only takes effect while processing is halted. Results leave the block as a one-cycle valid pulse with the channel, energy, timing product, quality value and an above-threshold flag.

Top module: `ofilt_proc`

## Requirements
- R1: The energy is E = sat((sum over taps i=0..4 of a_i*d_i) >>> FRAC_W), with FRAC_W = 10 and the shift arithmetic (floor). sat() clamps to the 18-bit signed range [-131072, 131071]. Tap i is `evtSamples[i*18 +: 18]`.
- R2: Each difference is d_i = sat(S_i - PED), with S_i and PED treated as unsigned 18-bit values. A difference above 131071 becomes 131071 and one below -131072 becomes -131072.
- R3: `resAbove` is 1 exactly when E > `thrLevel`, compared as signed values. A result equal to the threshold counts as below.
- R4: When above threshold, `resTiming` is the full 39-bit signed sum of b_i*d_i with no scaling.
- R5: When above threshold, `resQuality` is the sum of r_i squared, where r_i = sat(d_i - ((E*g_i) >>> FRAC_W)). The quality pass uses the finished energy E.
- R6: When not above threshold, `resTiming` and `resQuality` are 0 and `resAbove` is 0, while `resEnergy` still carries E.
- R7: `resValid` is a single-cycle pulse, and `resCh` carries the channel of the window. It rises 8 clock edges after the accepting edge for a below-threshold window and 23 edges after it for an above-threshold window.
- R8: A window is accepted only on an edge where `evtValid` and `evtReady` are both 1. `evtReady` is 0 while a window is in flight and while `cfgHalt` is 1. A window offered then is dropped and produces no result.
- R9: A configuration write stores `cfgData` only when `cfgWrEn` and `cfgHalt` are both 1. `cfgSel` selects the target: 0 for the pedestal, 1 for the energy weight a, 2 for the timing weight b, 3 for the shape weight g. A write with `cfgHalt` at 0 leaves the stored value unchanged.
- R10: After reset, `resValid` is 0, all result outputs are 0, and `evtReady` is 1 while `cfgHalt` is 0.
- R11: Pedestal and coefficients are kept per channel. A write to one channel does not change the results of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgHalt | input | 1 | Halts acceptance of windows and enables configuration writes |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Write target: 0 pedestal, 1 a, 2 b, 3 g |
| cfgCh | input | 4 | Channel addressed by the write |
| cfgTap | input | 3 | Tap addressed by a coefficient write |
| cfgData | input | 18 | Value written |
| thrLevel | input | 18 | Signed energy threshold |
| evtValid | input | 1 | Sample window offered |
| evtCh | input | 4 | Channel of the offered window |
| evtSamples | input | 90 | Five unsigned 18-bit samples, tap 0 in the low bits |
| evtReady | output | 1 | Block can accept a window this cycle |
| resValid | output | 1 | Result pulse |
| resCh | output | 4 | Channel of the result |
| resEnergy | output | 18 | Signed energy |
| resTiming | output | 39 | Signed timing product |
| resQuality | output | 38 | Unsigned quality sum |
| resAbove | output | 1 | Energy above threshold |

## Verification
The result of a window is due 8 edges after the accepting edge when the energy stays at or below the threshold. It is due 23 edges after that edge when the timing and quality passes run. `resValid` falls again one edge later. The bench counts rising edges from the accepting edge and samples every output on the falling edge between edges. It requires the pulse on exactly the predicted count and absent on the following sample. Expected values come from an integer model of the formulas above, computed in the bench from its own copy of the configuration writes.

// File: rtl/ofilt_pkg.sv
package ofilt_pkg;

  localparam int TAP_IDX_W = 3;

  typedef enum logic [1:0] {
    SRC_ENERGY = 2'd0,
    SRC_TIMING = 2'd1,
    SRC_GAIN   = 2'd2,
    SRC_SQUARE = 2'd3
  } mac_src_e;

  typedef enum logic [1:0] {
    CFG_PED = 2'd0,
    CFG_A   = 2'd1,
    CFG_B   = 2'd2,
    CFG_G   = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic                 loadEvt;
    logic                 subDiff;
    logic                 accClr;
    logic                 macEn;
    logic                 gainEn;
    logic                 latchEnergy;
    logic                 latchTiming;
    logic                 loadOut;
    mac_src_e             src;
    logic [TAP_IDX_W-1:0] tap;
  } dp_strobe_t;

endpackage

// File: rtl/ofilt_ctrl.sv
module ofilt_ctrl
  import ofilt_pkg::*;
#(
  parameter int NUM_TAPS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgHalt,
  input  logic       evtValid,
  input  logic       aboveNow,
  output logic       evtReady,
  output dp_strobe_t stb
);

  localparam logic [TAP_IDX_W-1:0] LAST_TAP = TAP_IDX_W'(NUM_TAPS - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SUB, ST_EACC, ST_EFIN, ST_TACC, ST_QACC, ST_FIN
  } state_e;

  state_e               state;
  logic [TAP_IDX_W-1:0] tapCnt;
  logic                 phase;
  logic                 energyDone;

  assign evtReady = (state == ST_IDLE) && !cfgHalt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tapCnt     <= '0;
      phase      <= 1'b0;
      energyDone <= 1'b0;
    end else begin
      if (stb.latchEnergy) energyDone <= 1'b1;
      else if (stb.loadOut) energyDone <= 1'b0;
      case (state)
        ST_IDLE: if (evtValid && !cfgHalt) state <= ST_SUB;
        ST_SUB: begin
          state  <= ST_EACC;
          tapCnt <= '0;
        end
        ST_EACC: begin
          if (tapCnt == LAST_TAP) begin
            state  <= ST_EFIN;
            tapCnt <= '0;
          end else begin
            tapCnt <= tapCnt + 1'b1;
          end
        end
        ST_EFIN: state <= aboveNow ? ST_TACC : ST_FIN;
        ST_TACC: begin
          if (tapCnt == LAST_TAP) begin
            state  <= ST_QACC;
            tapCnt <= '0;
            phase  <= 1'b0;
          end else begin
            tapCnt <= tapCnt + 1'b1;
          end
        end
        ST_QACC: begin
          phase <= !phase;
          if (phase) begin
            if (tapCnt == LAST_TAP) begin
              state  <= ST_FIN;
              tapCnt <= '0;
            end else begin
              tapCnt <= tapCnt + 1'b1;
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb     = '0;
    stb.tap = tapCnt;
    stb.src = SRC_ENERGY;
    case (state)
      ST_IDLE: stb.loadEvt = evtValid && !cfgHalt;
      ST_SUB: begin
        stb.subDiff = 1'b1;
        stb.accClr  = 1'b1;
      end
      ST_EACC: begin
        stb.macEn = 1'b1;
        stb.src   = SRC_ENERGY;
      end
      ST_EFIN: begin
        stb.latchEnergy = 1'b1;
        stb.accClr      = 1'b1;
      end
      ST_TACC: begin
        stb.macEn = 1'b1;
        stb.src   = SRC_TIMING;
      end
      ST_QACC: begin
        if (!phase) begin
          stb.gainEn = 1'b1;
          stb.src    = SRC_GAIN;
          if (tapCnt == '0) begin
            stb.latchTiming = 1'b1;
            stb.accClr      = 1'b1;
          end
        end else begin
          stb.macEn = 1'b1;
          stb.src   = SRC_SQUARE;
        end
      end
      ST_FIN:  stb.loadOut = 1'b1;
      default: stb.loadOut = 1'b0;
    endcase
  end

  // R5: the shape pass only runs once the energy has been latched
  a_r5_gain_after_energy: assert property (@(posedge clk) disable iff (!rst_n)
    stb.gainEn |-> energyDone);

  // R7: tap counter never leaves the tap range
  a_r7_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tapCnt <= LAST_TAP);

endmodule

// File: rtl/ofilt_datapath.sv
module ofilt_datapath
  import ofilt_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int NUM_TAPS = 5,
  parameter int DATA_W   = 18,
  parameter int FRAC_W   = 10,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int PROD_W  = 2 * DATA_W,
  localparam int ACC_W   = PROD_W + 3,
  localparam int QUAL_W  = ACC_W - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  dp_strobe_t                 stb,
  input  logic                       cfgHalt,
  input  logic                       cfgWrEn,
  input  logic [1:0]                 cfgSel,
  input  logic [CH_W-1:0]            cfgCh,
  input  logic [TAP_IDX_W-1:0]       cfgTap,
  input  logic [DATA_W-1:0]          cfgData,
  input  logic signed [DATA_W-1:0]   thrLevel,
  input  logic [CH_W-1:0]            evtCh,
  input  logic [NUM_TAPS*DATA_W-1:0] evtSamples,
  output logic                       aboveNow,
  output logic                       resValid,
  output logic [CH_W-1:0]            resCh,
  output logic signed [DATA_W-1:0]   resEnergy,
  output logic signed [ACC_W-1:0]    resTiming,
  output logic [QUAL_W-1:0]          resQuality,
  output logic                       resAbove
);

  localparam longint SAT_MAX_L = (64'sd1 <<< (DATA_W - 1)) - 64'sd1;
  localparam logic signed [ACC_W-1:0] SAT_MAX = ACC_W'(SAT_MAX_L);
  localparam logic signed [ACC_W-1:0] SAT_MIN = ACC_W'(-SAT_MAX_L - 64'sd1);

  function automatic logic signed [DATA_W-1:0] satData(input logic signed [ACC_W-1:0] v);
    if (v > SAT_MAX) return DATA_W'(SAT_MAX);
    if (v < SAT_MIN) return DATA_W'(SAT_MIN);
    return DATA_W'(v);
  endfunction

  logic [DATA_W-1:0]        pedMem [NUM_CH];
  logic signed [DATA_W-1:0] aMem   [NUM_CH][NUM_TAPS];
  logic signed [DATA_W-1:0] bMem   [NUM_CH][NUM_TAPS];
  logic signed [DATA_W-1:0] gMem   [NUM_CH][NUM_TAPS];

  logic [CH_W-1:0]          chReg;
  logic [DATA_W-1:0]        sampReg  [NUM_TAPS];
  logic signed [DATA_W-1:0] diffReg  [NUM_TAPS];
  logic signed [DATA_W-1:0] diffNext [NUM_TAPS];
  logic signed [DATA_W-1:0] energyReg;
  logic                     aboveReg;
  logic signed [ACC_W-1:0]  timingReg;
  logic signed [DATA_W-1:0] residReg;
  logic signed [ACC_W-1:0]  acc;

  logic signed [DATA_W-1:0] opA, opB;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] prodShift;
  logic signed [ACC_W-1:0]  residWide;
  logic signed [ACC_W-1:0]  accShift;
  logic signed [DATA_W-1:0] energyNext;

  logic cfgWrOk;
  assign cfgWrOk = cfgWrEn && cfgHalt && (cfgTap < TAP_IDX_W'(NUM_TAPS));

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        pedMem[c] <= '0;
        for (int t = 0; t < NUM_TAPS; t++) begin
          aMem[c][t] <= '0;
          bMem[c][t] <= '0;
          gMem[c][t] <= '0;
        end
      end
    end else if (cfgWrEn && cfgHalt) begin
      if (cfgSel == CFG_PED) pedMem[cfgCh] <= cfgData;
      else if (cfgWrOk) begin
        case (cfgSel)
          CFG_A:   aMem[cfgCh][cfgTap] <= cfgData;
          CFG_B:   bMem[cfgCh][cfgTap] <= cfgData;
          default: gMem[cfgCh][cfgTap] <= cfgData;
        endcase
      end
    end
  end

  // pedestal subtraction, one lane per tap
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_sub
    logic signed [DATA_W:0] rawDiff;
    assign rawDiff     = $signed({1'b0, sampReg[t]}) - $signed({1'b0, pedMem[chReg]});
    assign diffNext[t] = satData(ACC_W'(rawDiff));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chReg <= '0;
      for (int t = 0; t < NUM_TAPS; t++) begin
        sampReg[t] <= '0;
        diffReg[t] <= '0;
      end
    end else begin
      if (stb.loadEvt) begin
        chReg <= evtCh;
        for (int t = 0; t < NUM_TAPS; t++) sampReg[t] <= evtSamples[t*DATA_W +: DATA_W];
      end
      if (stb.subDiff) begin
        for (int t = 0; t < NUM_TAPS; t++) diffReg[t] <= diffNext[t];
      end
    end
  end

  // shared multiplier operand select
  always_comb begin
    case (stb.src)
      SRC_ENERGY: begin opA = aMem[chReg][stb.tap]; opB = diffReg[stb.tap]; end
      SRC_TIMING: begin opA = bMem[chReg][stb.tap]; opB = diffReg[stb.tap]; end
      SRC_GAIN:   begin opA = energyReg;            opB = gMem[chReg][stb.tap]; end
      default:    begin opA = residReg;             opB = residReg; end
    endcase
  end

  assign prod       = opA * opB;
  assign prodShift  = prod >>> FRAC_W;
  assign residWide  = ACC_W'(diffReg[stb.tap]) - ACC_W'(prodShift);
  assign accShift   = acc >>> FRAC_W;
  assign energyNext = satData(accShift);
  assign aboveNow   = energyNext > thrLevel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      energyReg <= '0;
      aboveReg  <= 1'b0;
      timingReg <= '0;
      residReg  <= '0;
    end else begin
      if (stb.latchEnergy) begin
        energyReg <= energyNext;
        aboveReg  <= aboveNow;
      end
      if (stb.latchTiming) timingReg <= acc;
      if (stb.gainEn) residReg <= satData(residWide);
      if (stb.accClr) acc <= '0;
      else if (stb.macEn) acc <= acc + ACC_W'(prod);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid   <= 1'b0;
      resCh      <= '0;
      resEnergy  <= '0;
      resTiming  <= '0;
      resQuality <= '0;
      resAbove   <= 1'b0;
    end else begin
      resValid <= stb.loadOut;
      if (stb.loadOut) begin
        resCh      <= chReg;
        resEnergy  <= energyReg;
        resAbove   <= aboveReg;
        resTiming  <= aboveReg ? timingReg : '0;
        resQuality <= aboveReg ? acc[QUAL_W-1:0] : '0;
      end
    end
  end

  // R5: each squared residual can only grow the quality sum
  a_r5_square_nondec: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.macEn && stb.src == SRC_SQUARE && !stb.accClr) |=> acc >= $past(acc));

endmodule

// File: rtl/ofilt_proc.sv
module ofilt_proc
  import ofilt_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int NUM_TAPS = 5,
  parameter int DATA_W   = 18,
  parameter int FRAC_W   = 10,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int ACC_W   = 2 * DATA_W + 3,
  localparam int QUAL_W  = ACC_W - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfgHalt,
  input  logic                       cfgWrEn,
  input  logic [1:0]                 cfgSel,
  input  logic [CH_W-1:0]            cfgCh,
  input  logic [TAP_IDX_W-1:0]       cfgTap,
  input  logic [DATA_W-1:0]          cfgData,
  input  logic signed [DATA_W-1:0]   thrLevel,
  input  logic                       evtValid,
  input  logic [CH_W-1:0]            evtCh,
  input  logic [NUM_TAPS*DATA_W-1:0] evtSamples,
  output logic                       evtReady,
  output logic                       resValid,
  output logic [CH_W-1:0]            resCh,
  output logic signed [DATA_W-1:0]   resEnergy,
  output logic signed [ACC_W-1:0]    resTiming,
  output logic [QUAL_W-1:0]          resQuality,
  output logic                       resAbove
);

  dp_strobe_t stb;
  logic       aboveNow;

  ofilt_ctrl #(.NUM_TAPS(NUM_TAPS)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgHalt  (cfgHalt),
    .evtValid (evtValid),
    .aboveNow (aboveNow),
    .evtReady (evtReady),
    .stb      (stb)
  );

  ofilt_datapath #(
    .NUM_CH   (NUM_CH),
    .NUM_TAPS (NUM_TAPS),
    .DATA_W   (DATA_W),
    .FRAC_W   (FRAC_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .cfgHalt    (cfgHalt),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .cfgCh      (cfgCh),
    .cfgTap     (cfgTap),
    .cfgData    (cfgData),
    .thrLevel   (thrLevel),
    .evtCh      (evtCh),
    .evtSamples (evtSamples),
    .aboveNow   (aboveNow),
    .resValid   (resValid),
    .resCh      (resCh),
    .resEnergy  (resEnergy),
    .resTiming  (resTiming),
    .resQuality (resQuality),
    .resAbove   (resAbove)
  );

  // R7: a result is announced for one cycle only
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |=> !resValid);

  // R6: below-threshold results carry no timing or quality
  a_r6_below_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resAbove) |-> (resTiming == '0 && resQuality == '0));

  // R8: an accepted window blocks further acceptance
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && evtReady) |=> !evtReady);

  // R8: halting stops acceptance
  a_r8_halt_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cfgHalt |-> !evtReady);

endmodule

// File: tb/ofilt_proc_tb_top.sv
module ofilt_proc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int NT  = 5;
  localparam int DW  = 18;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   cfgHalt = 1'b0;
  logic                   cfgWrEn = 1'b0;
  logic [1:0]             cfgSel = '0;
  logic [3:0]             cfgCh = '0;
  logic [2:0]             cfgTap = '0;
  logic [DW-1:0]          cfgData = '0;
  logic signed [DW-1:0]   thrLevel = '0;
  logic                   evtValid = 1'b0;
  logic [3:0]             evtCh = '0;
  logic [NT*DW-1:0]       evtSamples = '0;
  logic                   evtReady;
  logic                   resValid;
  logic [3:0]             resCh;
  logic signed [DW-1:0]   resEnergy;
  logic signed [38:0]     resTiming;
  logic [37:0]            resQuality;
  logic                   resAbove;

  int errors = 0;
  int checks = 0;

  longint mPed [NCH];
  longint mA [NCH][NT];
  longint mB [NCH][NT];
  longint mG [NCH][NT];
  longint evS [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  ofilt_proc dut_i (
    .clk(clk), .rst_n(rst_n), .cfgHalt(cfgHalt), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgCh(cfgCh), .cfgTap(cfgTap), .cfgData(cfgData), .thrLevel(thrLevel),
    .evtValid(evtValid), .evtCh(evtCh), .evtSamples(evtSamples), .evtReady(evtReady),
    .resValid(resValid), .resCh(resCh), .resEnergy(resEnergy), .resTiming(resTiming),
    .resQuality(resQuality), .resAbove(resAbove)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat18(longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  // independent model of the requirements
  task automatic model(int ch, longint thr, output longint e, output longint ab,
                       output longint t, output longint q);
    longint d [NT];
    longint sum = 0;
    t = 0;
    q = 0;
    for (int i = 0; i < NT; i++) d[i] = sat18(evS[i] - mPed[ch]);
    for (int i = 0; i < NT; i++) sum += mA[ch][i] * d[i];
    e = sat18(sum >>> 10);
    ab = (e > thr) ? 1 : 0;
    if (ab == 1) begin
      for (int i = 0; i < NT; i++) begin
        longint r;
        t += mB[ch][i] * d[i];
        r = sat18(d[i] - ((e * mG[ch][i]) >>> 10));
        q += r * r;
      end
    end
  endtask

  task automatic cfgWrite(int sel, int ch, int tap, longint val);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgSel  = 2'(sel);
    cfgCh   = 4'(ch);
    cfgTap  = 3'(tap);
    cfgData = DW'(val);
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (cfgHalt) begin
      case (sel)
        0: mPed[ch] = val;
        1: mA[ch][tap] = val;
        2: mB[ch][tap] = val;
        default: mG[ch][tap] = val;
      endcase
    end
  endtask

  task automatic loadChannel(int ch, longint ped, longint a[NT], longint b[NT], longint g[NT]);
    cfgWrite(0, ch, 0, ped);
    for (int i = 0; i < NT; i++) begin
      cfgWrite(1, ch, i, a[i]);
      cfgWrite(2, ch, i, b[i]);
      cfgWrite(3, ch, i, g[i]);
    end
  endtask

  task automatic driveWindow(int ch);
    @(negedge clk);
    while (!evtReady) @(negedge clk);
    evtValid = 1'b1;
    evtCh    = 4'(ch);
    for (int i = 0; i < NT; i++) evtSamples[i*DW +: DW] = DW'(evS[i]);
    @(posedge clk);
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  // runs one window and checks every output and its latency
  task automatic runEvent(int ch, longint thr, string tag);
    longint e, ab, t, q;
    int cyc = 0;
    thrLevel = DW'(thr);
    model(ch, thr, e, ab, t, q);
    driveWindow(ch);
    while (!resValid && cyc < 60) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    chk({"R7 ", tag}, "latency", cyc, (ab == 1) ? 23 : 8);
    chk({"R7 ", tag}, "channel", longint'(resCh), ch);
    chk({"R1 ", tag}, "energy", longint'(resEnergy), e);
    chk({"R3 ", tag}, "above flag", longint'(resAbove), ab);
    if (ab == 1) begin
      chk({"R4 ", tag}, "timing", longint'(resTiming), t);
      chk({"R5 ", tag}, "quality", longint'(resQuality), q);
    end else begin
      chk({"R6 ", tag}, "timing zero", longint'(resTiming), 0);
      chk({"R6 ", tag}, "quality zero", longint'(resQuality), 0);
    end
    @(negedge clk);
    chk({"R7 ", tag}, "pulse width", longint'(resValid), 0);
  endtask

  task automatic setPulse(longint ped, longint s0, longint s1, longint s2, longint s3, longint s4);
    evS[0] = ped + s0; evS[1] = ped + s1; evS[2] = ped + s2; evS[3] = ped + s3; evS[4] = ped + s4;
  endtask

  task automatic testReset();
    chk("R10", "resValid", longint'(resValid), 0);
    chk("R10", "evtReady", longint'(evtReady), 1);
    chk("R10", "energy", longint'(resEnergy), 0);
    chk("R10", "quality", longint'(resQuality), 0);
  endtask

  task automatic testConfig();
    longint a3[NT] = '{-100, 300, 700, 400, 100};
    longint b3[NT] = '{50, -200, 0, 200, -50};
    longint g3[NT] = '{100, 600, 1024, 700, 300};
    longint a5[NT] = '{200, 200, 200, 200, 200};
    longint b5[NT] = '{1, 2, 3, 4, 5};
    longint g5[NT] = '{10, 20, 30, 40, 50};
    longint aS[NT] = '{131071, 131071, 131071, 131071, 131071};
    longint bS[NT] = '{-131072, -131072, -131072, -131072, -131072};
    longint a7[NT] = '{1, 0, 0, 0, 0};
    longint b7[NT] = '{1, 1, 1, 1, 1};
    longint z[NT]  = '{0, 0, 0, 0, 0};
    @(negedge clk);
    cfgHalt = 1'b1;
    @(negedge clk);
    chk("R8", "ready while halted", longint'(evtReady), 0);
    loadChannel(3, 1000, a3, b3, g3);
    loadChannel(5, 500, a5, b5, g5);
    loadChannel(9, 10, aS, bS, aS);
    loadChannel(7, 262143, a7, b7, z);
    @(negedge clk);
    cfgHalt = 1'b0;
  endtask

  task automatic testBelow();
    setPulse(1000, 10, 400, 1000, 600, 200);
    runEvent(3, 2000, "below threshold");
  endtask

  task automatic testAbove();
    setPulse(1000, 10, 400, 1000, 600, 200);
    runEvent(3, 500, "above threshold");
  endtask

  task automatic testEqual();
    longint e, ab, t, q;
    setPulse(1000, 10, 400, 1000, 600, 200);
    model(3, 0, e, ab, t, q);
    runEvent(3, e, "equal to threshold (R3)");
    chk("R3", "equal counts as below", longint'(resAbove), 0);
  endtask

  task automatic testSaturation();
    evS[0] = 200000; evS[1] = 0; evS[2] = 262143; evS[3] = 100; evS[4] = 5;
    runEvent(9, 0, "positive clamp R2");
    for (int i = 0; i < NT; i++) evS[i] = 0;
    runEvent(7, -200, "negative clamp R2");
  endtask

  task automatic testBusy();
    int seen = 0;
    setPulse(500, 100, 300, 500, 300, 100);
    thrLevel = 18'sd1000000 >>> 4;
    driveWindow(5);
    for (int k = 0; k < 3; k++) begin
      chk("R8", "ready low in flight", longint'(evtReady), 0);
      evtValid = 1'b1;
      evtCh    = 4'd3;
      @(negedge clk);
    end
    evtValid = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (resValid) begin
        seen++;
        chk("R8", "first window channel", longint'(resCh), 5);
      end
      @(negedge clk);
    end
    chk("R8", "single result for busy offers", seen, 1);
  endtask

  task automatic testHalt();
    int seen = 0;
    @(negedge clk);
    cfgHalt  = 1'b1;
    evtValid = 1'b1;
    evtCh    = 4'd3;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (evtReady) seen++;
      if (resValid) seen++;
    end
    evtValid = 1'b0;
    cfgHalt  = 1'b0;
    chk("R8", "no acceptance while halted", seen, 0);
  endtask

  task automatic testRunWrite();
    setPulse(500, 100, 300, 500, 300, 100);
    cfgWrite(1, 5, 0, 9999);
    runEvent(5, -131072, "write while running ignored R9");
    @(negedge clk);
    cfgHalt = 1'b1;
    cfgWrite(1, 5, 0, 9999);
    cfgWrite(0, 5, 0, 450);
    @(negedge clk);
    cfgHalt = 1'b0;
    runEvent(5, -131072, "write while halted applied R9");
  endtask

  task automatic testIsolation();
    setPulse(1000, 10, 400, 1000, 600, 200);
    runEvent(3, 500, "other channel unchanged R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mPed[c] = 0;
      for (int i = 0; i < NT; i++) begin
        mA[c][i] = 0; mB[c][i] = 0; mG[c][i] = 0;
      end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testBelow();
    testAbove();
    testEqual();
    testSaturation();
    testBusy();
    testHalt();
    testRunWrite();
    testIsolation();
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule